// File: doc/BRIEF.md
# Integer Pipeline Hazard Controller

This unit decides when an in-order five-stage integer pipeline (fetch, decode, execute, memory access, write-back) has to hold an instruction in decode. It also decides where each execute-stage operand comes from. The datapath presents the decoded instruction: whether the slot is valid, its kind, its destination register and its two source registers with use flags. The unit keeps its own shadow copy of the destinations and kinds that sit in execute and memory access, and uses it to judge every new decode slot.

A stall output holds the PC and the fetch/decode register. A bubble output replaces the entry to the execute stage with a no-operation. Two select outputs drive the execute-stage operand multiplexers. The selects are registered, so they apply to the instruction that is in execute during that cycle.

The `FWD_EN` parameter chooses between two modes. One bypasses results from the later stages. The other is a pure interlock that waits for write-back. Branches are resolved in decode, so a branch needs its operands earlier than an ordinary instruction does, and it has its own stall rules. The register file writes in the first half of a cycle and reads in the second half, so a producer that is in write-back never causes a stall.

Top module: `pipe_hazard_unit`

## Requirements
- R1: While `rstN` is low, and in the first cycle after it is released, `stall`, `bubble`, `fwdSelA` and `fwdSelB` are all 0. After reset the execute and memory shadow stages are empty.
- R2: `bubble` equals `stall` in every cycle. After a stall cycle the execute stage holds a no-operation: both selects are 0 in the next cycle, and that slot causes no hazard later.
- R3: Forwarding mode. Suppose an ALU instruction (kind 1) writes a register and the next instruction reads it. There is no stall, and in the consumer's execute cycle the matching select is 1 (execute/memory latch).
- R4: Forwarding mode. If the producer is two instructions ahead, there is no stall and the select is 2 (memory/write-back latch).
- R5: A producer three or more instructions ahead causes neither a stall nor a bypass (select 0) in either mode.
- R6: Forwarding mode. A load (kind 2) followed directly by a non-branch reader of its result gives exactly one stall cycle. The reader then executes with select 2.
- R7: When several in-flight producers write the same register, the youngest one determines the stall and the select.
- R8: Forwarding mode. A branch (kind 3) in decode stalls one cycle if an ALU instruction directly ahead writes one of its sources. It stalls two cycles if a load directly ahead writes one of its sources. It does not stall for an ALU producer two ahead.
- R9: Interlock mode (`FWD_EN`=0). A reader stalls for as long as a producer of one of its sources is in execute or memory access. Both selects are always 0.
- R10: Register 0 never causes a stall or a bypass, whether it appears as a source or as a destination.
- R11: A source whose use flag is 0 is ignored. A decode slot with `idValid` low never stalls and writes nothing. Kinds 0 and 3 write no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| idValid | input | 1 | Decode slot holds a real instruction |
| idKind | input | 2 | 0 none, 1 ALU, 2 load, 3 branch |
| idDst | input | REG_W | Destination register of the decode instruction |
| idSrcA | input | REG_W | First source register |
| idUseA | input | 1 | First source is read |
| idSrcB | input | REG_W | Second source register |
| idUseB | input | 1 | Second source is read |
| stall | output | 1 | Hold PC and fetch/decode register |
| bubble | output | 1 | Load a no-operation into the decode/execute register |
| fwdSelA | output | 2 | Execute operand A source: 0 register file, 1 execute/memory latch, 2 memory/write-back latch |
| fwdSelB | output | 2 | Execute operand B source, same encoding |

## Verification
Two things can happen in one cycle: the unit can stall the instruction in decode while it also hands a bypass select to the instruction in execute. The bench provokes this with short dependent programs such as a load, an unrelated ALU operation and a reader of both results, and runs the same programs through a forwarding instance and an interlock instance in lock-step. A behavioural reference keeps the in-flight producers in queues. Every clock it predicts the stall and the selects of the instruction that just entered execute, and compares them with the outputs. The total number of stall cycles in each program is also compared with a count worked out by hand.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

  localparam int NUM_OPND = 2;

  typedef enum logic [1:0] {
    KIND_NONE   = 2'd0,
    KIND_ALU    = 2'd1,
    KIND_LOAD   = 2'd2,
    KIND_BRANCH = 2'd3
  } instrKind_e;

  typedef enum logic [1:0] {
    SEL_REGFILE = 2'd0,
    SEL_EXMEM   = 2'd1,
    SEL_MEMWB   = 2'd2
  } opndSel_e;

  // Per-source comparison result handed from the tracker to the control.
  typedef struct packed {
    logic exHit;
    logic exLoad;
    logic memHit;
    logic memLoad;
  } srcMatch_t;

  // Strobes from the control back to the tracker.
  typedef struct packed {
    logic     insertBubble;
    opndSel_e selA;
    opndSel_e selB;
  } ctlStrobe_t;

endpackage

// File: rtl/hzd_track.sv
module hzd_track
  import hzd_pkg::*;
#(
  parameter int REG_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idValid,
  input  logic [1:0]       idKind,
  input  logic [REG_W-1:0] idDst,
  input  logic [REG_W-1:0] idSrcA,
  input  logic             idUseA,
  input  logic [REG_W-1:0] idSrcB,
  input  logic             idUseB,
  input  ctlStrobe_t       strobe,
  output srcMatch_t        matchA,
  output srcMatch_t        matchB,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB
);

  typedef struct packed {
    logic             wr;
    logic             load;
    logic [REG_W-1:0] dst;
  } stage_t;

  stage_t     idS, exS, memS;
  opndSel_e   exSelA, exSelB;
  instrKind_e kind;

  logic [REG_W-1:0] src     [NUM_OPND];
  logic             srcUsed [NUM_OPND];
  srcMatch_t        match   [NUM_OPND];

  assign kind       = instrKind_e'(idKind);
  assign src[0]     = idSrcA;
  assign src[1]     = idSrcB;
  assign srcUsed[0] = idUseA;
  assign srcUsed[1] = idUseB;

  // Decode-slot summary as it would enter execute.
  always_comb begin
    idS.wr   = idValid && (kind == KIND_ALU || kind == KIND_LOAD) && (idDst != '0);
    idS.load = idValid && (kind == KIND_LOAD);
    idS.dst  = idDst;
  end

  // One comparator set per source operand.
  for (genvar g = 0; g < NUM_OPND; g++) begin : g_opnd
    logic live;
    assign live = srcUsed[g] && (src[g] != '0);
    assign match[g] = {live && exS.wr  && (exS.dst  == src[g]), exS.load,
                       live && memS.wr && (memS.dst == src[g]), memS.load};
  end

  assign matchA = match[0];
  assign matchB = match[1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      exS    <= '0;
      memS   <= '0;
      exSelA <= SEL_REGFILE;
      exSelB <= SEL_REGFILE;
    end else begin
      memS <= exS;
      if (strobe.insertBubble) begin
        exS    <= '0;
        exSelA <= SEL_REGFILE;
        exSelB <= SEL_REGFILE;
      end else begin
        exS    <= idS;
        exSelA <= strobe.selA;
        exSelB <= strobe.selB;
      end
    end
  end

  assign fwdSelA = exSelA;
  assign fwdSelB = exSelB;

endmodule

// File: rtl/hzd_ctrl.sv
module hzd_ctrl
  import hzd_pkg::*;
#(
  parameter int FWD_EN = 1
) (
  input  logic       idValid,
  input  logic [1:0] idKind,
  input  srcMatch_t  matchA,
  input  srcMatch_t  matchB,
  output ctlStrobe_t strobe
);

  logic      isBranch;
  srcMatch_t m        [NUM_OPND];
  logic      needHold [NUM_OPND];
  opndSel_e  sel      [NUM_OPND];

  assign isBranch = (instrKind_e'(idKind) == KIND_BRANCH);
  assign m[0]     = matchA;
  assign m[1]     = matchB;

  for (genvar g = 0; g < NUM_OPND; g++) begin : g_rule
    if (FWD_EN != 0) begin : g_fwd
      // Branch reads in decode: needs EX result a cycle later, load data two.
      assign needHold[g] = isBranch ? (m[g].exHit || (m[g].memHit && m[g].memLoad))
                                    : (m[g].exHit && m[g].exLoad);
      assign sel[g] = !idValid    ? SEL_REGFILE :
                      m[g].exHit  ? SEL_EXMEM   :
                      m[g].memHit ? SEL_MEMWB   : SEL_REGFILE;
    end else begin : g_ilk
      // Wait until the producer has reached write-back.
      assign needHold[g] = m[g].exHit || m[g].memHit;
      assign sel[g]      = SEL_REGFILE;
    end
  end

  assign strobe = '{insertBubble: idValid && (needHold[0] || needHold[1]),
                    selA:         sel[0],
                    selB:         sel[1]};

endmodule

// File: rtl/pipe_hazard_unit.sv
module pipe_hazard_unit
  import hzd_pkg::*;
#(
  parameter int REG_W  = 5,
  parameter int FWD_EN = 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             idValid,
  input  logic [1:0]       idKind,
  input  logic [REG_W-1:0] idDst,
  input  logic [REG_W-1:0] idSrcA,
  input  logic             idUseA,
  input  logic [REG_W-1:0] idSrcB,
  input  logic             idUseB,
  output logic             stall,
  output logic             bubble,
  output logic [1:0]       fwdSelA,
  output logic [1:0]       fwdSelB
);

  ctlStrobe_t strobe;
  srcMatch_t  matchA, matchB;

  hzd_ctrl #(.FWD_EN(FWD_EN)) ctlI (
    .idValid (idValid),
    .idKind  (idKind),
    .matchA  (matchA),
    .matchB  (matchB),
    .strobe  (strobe)
  );

  hzd_track #(.REG_W(REG_W)) trkI (
    .clk     (clk),
    .rstN    (rstN),
    .idValid (idValid),
    .idKind  (idKind),
    .idDst   (idDst),
    .idSrcA  (idSrcA),
    .idUseA  (idUseA),
    .idSrcB  (idSrcB),
    .idUseB  (idUseB),
    .strobe  (strobe),
    .matchA  (matchA),
    .matchB  (matchB),
    .fwdSelA (fwdSelA),
    .fwdSelB (fwdSelB)
  );

  assign stall  = strobe.insertBubble;
  assign bubble = strobe.insertBubble;

endmodule

// File: rtl/pipe_hazard_chk.sv
module pipe_hazard_chk #(
  parameter int REG_W  = 5,
  parameter int FWD_EN = 1
) (
  input logic             clk,
  input logic             rstN,
  input logic             idValid,
  input logic [REG_W-1:0] idSrcA,
  input logic             idUseA,
  input logic [REG_W-1:0] idSrcB,
  input logic             idUseB,
  input logic             stall,
  input logic             bubble,
  input logic [1:0]       fwdSelA,
  input logic [1:0]       fwdSelB
);

  // R2
  squash_after_stall_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stall && bubble) |=> (fwdSelA == 2'd0 && fwdSelB == 2'd0));

  // R11
  idle_slot_chk: assert property (@(posedge clk) disable iff (!rstN)
    !idValid |-> !stall);

  // R10
  no_live_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    (idValid && (!idUseA || idSrcA == '0) && (!idUseB || idSrcB == '0)) |-> !stall);

  // R8
  stall_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    (stall ##1 stall) |=> !stall);

  // R3
  sel_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    (fwdSelA != 2'd3) && (fwdSelB != 2'd3));

  if (FWD_EN == 0) begin : g_ilk_chk
    // R9
    ilk_sel_chk: assert property (@(posedge clk) disable iff (!rstN)
      (fwdSelA == 2'd0) && (fwdSelB == 2'd0));
  end

endmodule

bind pipe_hazard_unit pipe_hazard_chk #(.REG_W(REG_W), .FWD_EN(FWD_EN)) chkI (.*);

// File: tb/pipe_hazard_unit_test.sv
module pipe_hazard_unit_test;

  localparam int CLK_PERIOD = 10;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // Index 1: forwarding instance, index 0: interlock instance.
  logic          vld [2];
  logic [1:0]    knd [2];
  logic [RW-1:0] dstR[2];
  logic [RW-1:0] srcA[2];
  logic [RW-1:0] srcB[2];
  logic          useA[2];
  logic          useB[2];
  logic          stl [2];
  logic          bub [2];
  logic [1:0]    selA[2];
  logic [1:0]    selB[2];

  pipe_hazard_unit #(.REG_W(RW), .FWD_EN(1)) uut (
    .clk(clk), .rstN(rstN), .idValid(vld[1]), .idKind(knd[1]), .idDst(dstR[1]),
    .idSrcA(srcA[1]), .idUseA(useA[1]), .idSrcB(srcB[1]), .idUseB(useB[1]),
    .stall(stl[1]), .bubble(bub[1]), .fwdSelA(selA[1]), .fwdSelB(selB[1]));

  pipe_hazard_unit #(.REG_W(RW), .FWD_EN(0)) uutIlk (
    .clk(clk), .rstN(rstN), .idValid(vld[0]), .idKind(knd[0]), .idDst(dstR[0]),
    .idSrcA(srcA[0]), .idUseA(useA[0]), .idSrcB(srcB[0]), .idUseB(useB[0]),
    .stall(stl[0]), .bubble(bub[0]), .fwdSelA(selA[0]), .fwdSelB(selB[0]));

  typedef struct {
    int kind;  // -1 idle slot, else 0..3
    int dst;
    int a;
    int b;
    bit ua;
    bit ub;
  } instr_t;

  instr_t prog[$];
  int     fDst[2][$];   // in-flight written register (0 = none), index 0 youngest
  bit     fLd [2][$];
  int     eSelA[2];
  int     eSelB[2];
  int     pc[2];
  int     stallCnt[2];
  int     checks = 0;
  int     errors = 0;
  bit     done = 0;

  task automatic check(string tag, int m, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s mode%0d %s: actual %0d expected %0d", tag, m, what, act, exp);
    end
  endtask

  task automatic add(int k, int d, int a, int b, bit ua, bit ub);
    instr_t c;
    c.kind = k; c.dst = d; c.a = a; c.b = b; c.ua = ua; c.ub = ub;
    prog.push_back(c);
  endtask

  function automatic instr_t curInstr(int m);
    instr_t c;
    if (pc[m] < prog.size()) c = prog[pc[m]];
    else begin c.kind = -1; c.dst = 0; c.a = 0; c.b = 0; c.ua = 0; c.ub = 0; end
    return c;
  endfunction

  function automatic int youngest(int m, int r);
    if (r == 0) return 0;
    for (int i = 0; i < fDst[m].size(); i++)
      if (fDst[m][i] == r) return i + 1;
    return 0;
  endfunction

  task automatic drive(int m);
    instr_t c = curInstr(m);
    vld[m]  = (c.kind >= 0);
    knd[m]  = (c.kind >= 0) ? 2'(c.kind) : 2'd0;
    dstR[m] = RW'(c.dst);
    srcA[m] = RW'(c.a);
    srcB[m] = RW'(c.b);
    useA[m] = c.ua;
    useB[m] = c.ub;
  endtask

  task automatic step(string tag, int m);
    instr_t c = curInstr(m);
    int expStall = 0;
    int sl[2];
    sl[0] = 0; sl[1] = 0;
    if (c.kind >= 0) begin
      for (int op = 0; op < 2; op++) begin
        int r, d;
        bit ld;
        r  = (op == 0) ? (c.ua ? c.a : 0) : (c.ub ? c.b : 0);
        d  = youngest(m, r);
        ld = (d > 0) && fLd[m][d-1];
        if (m == 1) begin
          if (c.kind == 3) begin
            if (d == 1 || (d == 2 && ld)) expStall = 1;
          end else if (d == 1 && ld) expStall = 1;
          sl[op] = (d == 1) ? 1 : (d == 2) ? 2 : 0;
        end else if (d == 1 || d == 2) expStall = 1;
      end
    end
    check(tag, m, "stall", int'(stl[m]), expStall);
    check("R2", m, "bubble", int'(bub[m]), expStall);
    check(tag, m, "fwdSelA", int'(selA[m]), eSelA[m]);
    check(tag, m, "fwdSelB", int'(selB[m]), eSelB[m]);
    if (expStall != 0) begin
      fDst[m].push_front(0);
      fLd[m].push_front(1'b0);
      eSelA[m] = 0; eSelB[m] = 0;
      stallCnt[m]++;
    end else begin
      bit wr = (c.kind == 1 || c.kind == 2) && c.dst != 0;
      fDst[m].push_front(wr ? c.dst : 0);
      fLd[m].push_front(c.kind == 2);
      eSelA[m] = sl[0]; eSelB[m] = sl[1];
      pc[m]++;
    end
    if (fDst[m].size() > 3) begin
      void'(fDst[m].pop_back());
      void'(fLd[m].pop_back());
    end
  endtask

  task automatic runScenario(string tag, int expFwd, int expIlk);
    for (int i = 0; i < 3; i++) add(-1, 0, 0, 0, 0, 0);
    for (int m = 0; m < 2; m++) begin pc[m] = 0; stallCnt[m] = 0; end
    while (pc[0] < prog.size() || pc[1] < prog.size()) begin
      @(posedge clk); #1;
      for (int m = 0; m < 2; m++) drive(m);
      @(negedge clk);
      for (int m = 0; m < 2; m++) step(tag, m);
    end
    check(tag, 1, "stall cycles", stallCnt[1], expFwd);
    check(tag, 0, "stall cycles", stallCnt[0], expIlk);
    prog.delete();
  endtask

  task automatic finishRun();
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual hung expected finished");
      finishRun();
    end
  end

  initial begin
    for (int m = 0; m < 2; m++) begin
      vld[m] = 0; knd[m] = 0; dstR[m] = 0; srcA[m] = 0; srcB[m] = 0;
      useA[m] = 0; useB[m] = 0; eSelA[m] = 0; eSelB[m] = 0;
    end
    // R1: outputs during reset
    repeat (3) @(negedge clk);
    for (int m = 0; m < 2; m++) begin
      check("R1", m, "stall in reset", int'(stl[m]), 0);
      check("R1", m, "bubble in reset", int'(bub[m]), 0);
      check("R1", m, "fwdSelA in reset", int'(selA[m]), 0);
      check("R1", m, "fwdSelB in reset", int'(selB[m]), 0);
    end
    rstN = 1'b1;

    // R1: reader right after reset sees empty pipeline
    add(1, 2, 1, 3, 1, 1);
    runScenario("R1", 0, 0);
    // R3: ALU producer directly ahead
    add(1, 1, 2, 3, 1, 1); add(1, 4, 1, 5, 1, 1);
    runScenario("R3", 0, 2);
    // R4: producer two ahead on source B
    add(1, 1, 2, 3, 1, 1); add(1, 6, 7, 7, 1, 1); add(1, 8, 9, 1, 1, 1);
    runScenario("R4", 0, 1);
    // R4: both operands bypassed from different stages
    add(2, 1, 2, 0, 1, 0); add(1, 2, 3, 4, 1, 1); add(1, 3, 1, 2, 1, 1);
    runScenario("R4", 0, 2);
    // R5: producer three ahead
    add(1, 1, 2, 3, 1, 1); add(1, 2, 5, 5, 1, 1); add(1, 3, 6, 6, 1, 1); add(1, 4, 1, 1, 1, 1);
    runScenario("R5", 0, 0);
    // R6: load-use
    add(2, 1, 2, 0, 1, 0); add(1, 4, 1, 5, 1, 1);
    runScenario("R6", 1, 2);
    // R7: two writers of the same register, youngest wins
    add(1, 1, 2, 3, 1, 1); add(1, 1, 4, 5, 1, 1); add(1, 6, 1, 1, 1, 1);
    runScenario("R7", 0, 2);
    // R7: older ALU, younger load of same register
    add(1, 1, 2, 3, 1, 1); add(2, 1, 4, 0, 1, 0); add(1, 6, 1, 7, 1, 1);
    runScenario("R7", 1, 2);
    // R8: branch after ALU producer
    add(1, 1, 2, 3, 1, 1); add(3, 0, 1, 0, 1, 1);
    runScenario("R8", 1, 2);
    // R8: branch after load producer
    add(2, 1, 2, 0, 1, 0); add(3, 0, 1, 0, 1, 1);
    runScenario("R8", 2, 2);
    // R8: branch with ALU producer two ahead
    add(1, 1, 2, 3, 1, 1); add(1, 6, 7, 7, 1, 1); add(3, 0, 1, 0, 1, 1);
    runScenario("R8", 0, 1);
    // R9: interlock waits on a load two ahead while forwarding does not
    add(2, 5, 2, 0, 1, 0); add(1, 6, 7, 8, 1, 1); add(1, 9, 5, 5, 1, 1);
    runScenario("R9", 0, 1);
    // R10: register 0 as destination and as source
    add(1, 0, 1, 2, 1, 1); add(1, 2, 0, 0, 1, 1); add(2, 0, 3, 0, 1, 0); add(3, 0, 0, 0, 1, 1);
    runScenario("R10", 0, 0);
    // R11: unused source field matches, kind 0 and branch write nothing
    add(1, 1, 2, 3, 1, 1); add(1, 2, 1, 3, 0, 1); add(0, 4, 5, 5, 0, 0); add(3, 6, 7, 7, 1, 1);
    add(1, 8, 4, 6, 1, 1);
    runScenario("R11", 0, 0);
    // R11: invalid slot carrying a matching source
    add(2, 1, 2, 0, 1, 0); add(-1, 0, 1, 1, 1, 1); add(1, 4, 1, 0, 1, 0);
    runScenario("R11", 0, 1);

    finishRun();
  end

endmodule